// File: doc/BRIEF.md
# Lookahead Earliest-Critical Refill Selector

This block decides, once every refill period, which per-queue head cache of a hybrid SRAM/DRAM packet buffer receives the next block of bytes from DRAM. Byte requests from the output scheduler do not go straight to the head caches. Each one enters a shift register of `LOOK` slots, so the block knows the demand for the next `LOOK` slots before it has to serve them. One request leaves the oldest slot every cycle and consumes one byte from the head cache of its queue. The block keeps a byte count for each head cache.

Every `BLEN` cycles one refill of `BLEN` bytes is granted. A queue counts as critical when it has more requests waiting in the shift register than bytes in its head cache. The shift register is searched from oldest to newest with a running count for each queue. The grant goes to the queue whose count first exceeds its byte count, which is the queue that would run dry first.

When no queue is critical, the grant goes to the queue with the largest deficit, meaning waiting requests minus bytes held, with the lowest index winning a tie. A queue whose cache has no room for a whole refill block is never granted. The refill grant is the block's output toward the DRAM side, and the bytes are counted as arriving in the same cycle.

Top module: `lacq_refill_sel`

## Requirements
- R1: While `rst` is high and in the first cycle after it falls, the lookahead register is empty and every head-cache count is zero. `serve_valid`, `underrun` and `refill_valid` read 0.
- R2: A request captured with `req_valid` at the end of cycle c is presented on `serve_valid`/`serve_qid` during cycle c+`LOOK`, with the same queue index. At most one request is served per cycle.
- R3: A refill can be granted only in cycles n (counting the first cycle after reset as 0) with n mod `BLEN` = `BLEN`-1. At most one queue is granted, and that queue's count grows by `BLEN`.
- R4: A grant with `refill_reason` = 1 (critical) names the queue of the oldest lookahead entry at which that queue's running request count, taken from the oldest entry up to and including this one, exceeds its current byte count.
- R5: When no queue is critical, the grant carries `refill_reason` = 2 (deficit) and names the queue with the largest value of waiting requests minus bytes held, among queues with room. On a tie the lowest index wins.
- R6: No grant is made to a queue whose count plus `BLEN` would exceed `HDEPTH`. If the chosen queue (or, in the fallback case, every queue) lacks room, `refill_valid` stays 0 on that refill cycle with `refill_reason` = 0, and no count ever exceeds `HDEPTH`.
- R7: A served request removes one byte from its queue's count. A refill granted to the same queue in the same cycle is usable by it. If no byte is available, `underrun` is 1 in that cycle and the count stays at zero.
- R8: With `LOOK` ≥ `NQ`·(`BLEN`-1)+1 and `HDEPTH` ≥ `LOOK`+`BLEN` (the defaults `LOOK` = `NQ`·`BLEN`, `HDEPTH` = `LOOK`+`BLEN`), `underrun` never rises for any request stream of at most one request per cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; one cycle is one byte slot |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | A byte request enters the lookahead register this cycle |
| req_qid | input | QW | Queue index of the entering request |
| serve_valid | output | 1 | A request leaves the oldest lookahead slot this cycle |
| serve_qid | output | QW | Queue index of the request being served |
| underrun | output | 1 | The served queue had no byte available |
| refill_valid | output | 1 | A refill of BLEN bytes is granted this cycle |
| refill_qid | output | QW | Queue index receiving the refill |
| refill_reason | output | 2 | 0 none, 1 critical queue, 2 largest deficit |

## Verification
The assertions assume that `req_qid` stays below `NQ` whenever `req_valid` is high and that at most one request arrives per cycle. The stimulus draws queue indices only from 0 to `NQ`-1 and drives one request per cycle at most. The no-underrun property also relies on the parameter relations in R8. The bench keeps the relations on the default instance and breaks them on purpose on a second, short-lookahead instance, where underruns must occur and must match the reference model cycle for cycle. Long idle stretches push every cache to full, so that the room rule in R6 suppresses grants.

// File: rtl/lacq_pkg.sv
`timescale 1ns/1ps
package lacq_pkg;

    // Reason attached to a refill grant.
    typedef enum logic [1:0] {
        RSN_NONE    = 2'd0,
        RSN_CRIT    = 2'd1,
        RSN_DEFICIT = 2'd2
    } refill_rsn_e;

    // Width of an index or counter able to address n distinct values.
    function automatic int idx_w(input int n);
        return (n < 2) ? 1 : $clog2(n);
    endfunction

endpackage

// File: rtl/lacq_lookahead.sv
`timescale 1ns/1ps
module lacq_lookahead #(
    parameter int LOOK = 8,
    parameter int QW   = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          in_vld,
    input  logic [QW-1:0] in_qid,
    output logic          slot_vld [LOOK],
    output logic [QW-1:0] slot_qid [LOOK]
);

    typedef struct packed {
        logic          vld;
        logic [QW-1:0] qid;
    } slot_t;

    // pipe[0] is the oldest entry and is served in the current cycle.
    slot_t pipe [LOOK];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < LOOK; i++) pipe[i] <= '0;
        end else begin
            for (int i = 0; i < LOOK - 1; i++) pipe[i] <= pipe[i+1];
            pipe[LOOK-1] <= {in_vld, in_qid};
        end
    end

    for (genvar i = 0; i < LOOK; i++) begin : g_out
        assign slot_vld[i] = pipe[i].vld;
        assign slot_qid[i] = pipe[i].qid;
    end

endmodule

// File: rtl/lacq_occupancy.sv
`timescale 1ns/1ps
module lacq_occupancy #(
    parameter int NQ     = 4,
    parameter int BLEN   = 2,
    parameter int HDEPTH = 10,
    parameter int QW     = 2,
    parameter int OW     = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          serve_vld,
    input  logic [QW-1:0] serve_qid,
    input  logic          fill_vld,
    input  logic [QW-1:0] fill_qid,
    output logic [OW-1:0] occ [NQ],
    output logic          underrun
);

    localparam logic [OW:0] FILL_AMT = BLEN[OW:0];

    logic [OW:0] avail [NQ];
    logic [OW:0] nxt   [NQ];

    // Bytes usable this slot: held bytes plus a refill landing now.
    always_comb begin
        for (int q = 0; q < NQ; q++) begin
            avail[q] = {1'b0, occ[q]} +
                       ((fill_vld && fill_qid == QW'(q)) ? FILL_AMT : '0);
            if (serve_vld && serve_qid == QW'(q) && avail[q] != '0)
                nxt[q] = avail[q] - 1'b1;
            else
                nxt[q] = avail[q];
        end
    end

    assign underrun = serve_vld && (avail[serve_qid] == '0);

    for (genvar q = 0; q < NQ; q++) begin : g_cnt
        always_ff @(posedge clk) begin
            if (rst) occ[q] <= '0;
            else     occ[q] <= nxt[q][OW-1:0];
        end
    end

endmodule

// File: rtl/lacq_pick.sv
`timescale 1ns/1ps
module lacq_pick
    import lacq_pkg::*;
#(
    parameter int NQ     = 4,
    parameter int BLEN   = 2,
    parameter int LOOK   = 8,
    parameter int HDEPTH = 10,
    parameter int QW     = 2,
    parameter int OW     = 4,
    parameter int CW     = 4
) (
    input  logic          slot_vld [LOOK],
    input  logic [QW-1:0] slot_qid [LOOK],
    input  logic [OW-1:0] occ      [NQ],
    output logic [CW-1:0] pend     [NQ],
    output logic          sel_vld,
    output logic [QW-1:0] sel_qid,
    output refill_rsn_e   sel_rsn
);

    logic          crit_found;
    logic [QW-1:0] crit_qid;
    logic          best_found;
    logic [QW-1:0] best_qid;
    logic [NQ-1:0] room;

    // Oldest-to-newest scan: the first entry whose running count for its
    // queue passes that queue's byte count marks the earliest critical queue.
    always_comb begin
        int run [NQ];
        for (int q = 0; q < NQ; q++) run[q] = 0;
        crit_found = 1'b0;
        crit_qid   = '0;
        for (int i = 0; i < LOOK; i++) begin
            if (slot_vld[i]) begin
                run[slot_qid[i]] = run[slot_qid[i]] + 1;
                if (!crit_found && run[slot_qid[i]] > int'(occ[slot_qid[i]])) begin
                    crit_found = 1'b1;
                    crit_qid   = slot_qid[i];
                end
            end
        end
        for (int q = 0; q < NQ; q++) pend[q] = CW'(run[q]);
    end

    // Headroom for a whole refill block.
    always_comb begin
        for (int q = 0; q < NQ; q++)
            room[q] = (int'(occ[q]) + BLEN) <= HDEPTH;
    end

    // Fallback: largest (pending - held), lowest index on a tie.
    always_comb begin
        int best_def;
        int def;
        best_found = 1'b0;
        best_qid   = '0;
        best_def   = 0;
        for (int q = 0; q < NQ; q++) begin
            def = int'(pend[q]) - int'(occ[q]);
            if (room[q] && (!best_found || def > best_def)) begin
                best_found = 1'b1;
                best_qid   = QW'(q);
                best_def   = def;
            end
        end
    end

    always_comb begin
        if (crit_found) begin
            sel_vld = room[crit_qid];
            sel_qid = crit_qid;
            sel_rsn = room[crit_qid] ? RSN_CRIT : RSN_NONE;
        end else begin
            sel_vld = best_found;
            sel_qid = best_qid;
            sel_rsn = best_found ? RSN_DEFICIT : RSN_NONE;
        end
    end

endmodule

// File: rtl/lacq_refill_sel.sv
`timescale 1ns/1ps
module lacq_refill_sel
    import lacq_pkg::*;
#(
    parameter int  NQ     = 4,
    parameter int  BLEN   = 2,
    parameter int  LOOK   = NQ * BLEN,
    parameter int  HDEPTH = LOOK + BLEN,
    localparam int QW     = idx_w(NQ)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          req_valid,
    input  logic [QW-1:0] req_qid,
    output logic          serve_valid,
    output logic [QW-1:0] serve_qid,
    output logic          underrun,
    output logic          refill_valid,
    output logic [QW-1:0] refill_qid,
    output logic [1:0]    refill_reason
);

    localparam int OW = idx_w(HDEPTH + 1);
    localparam int CW = idx_w(LOOK + 1);
    localparam int PW = idx_w(BLEN);

    logic          slot_vld [LOOK];
    logic [QW-1:0] slot_qid [LOOK];
    logic [OW-1:0] occ      [NQ];
    logic [CW-1:0] pend     [NQ];
    logic          sel_vld;
    logic [QW-1:0] sel_qid;
    refill_rsn_e   sel_rsn;
    logic [PW-1:0] phase;
    logic          tick;

    lacq_lookahead #(.LOOK(LOOK), .QW(QW)) u_look (
        .clk      (clk),
        .rst      (rst),
        .in_vld   (req_valid),
        .in_qid   (req_qid),
        .slot_vld (slot_vld),
        .slot_qid (slot_qid)
    );

    lacq_pick #(
        .NQ(NQ), .BLEN(BLEN), .LOOK(LOOK), .HDEPTH(HDEPTH),
        .QW(QW), .OW(OW), .CW(CW)
    ) u_pick (
        .slot_vld (slot_vld),
        .slot_qid (slot_qid),
        .occ      (occ),
        .pend     (pend),
        .sel_vld  (sel_vld),
        .sel_qid  (sel_qid),
        .sel_rsn  (sel_rsn)
    );

    // Refill slot counter: one grant opportunity every BLEN cycles.
    assign tick = (phase == PW'(BLEN - 1));

    always_ff @(posedge clk) begin
        if (rst)       phase <= '0;
        else if (tick) phase <= '0;
        else           phase <= phase + 1'b1;
    end

    assign refill_valid  = tick && sel_vld;
    assign refill_qid    = sel_qid;
    assign refill_reason = refill_valid ? sel_rsn : RSN_NONE;
    assign serve_valid   = slot_vld[0];
    assign serve_qid     = slot_qid[0];

    lacq_occupancy #(
        .NQ(NQ), .BLEN(BLEN), .HDEPTH(HDEPTH), .QW(QW), .OW(OW)
    ) u_occ (
        .clk       (clk),
        .rst       (rst),
        .serve_vld (serve_valid),
        .serve_qid (serve_qid),
        .fill_vld  (refill_valid),
        .fill_qid  (refill_qid),
        .occ       (occ),
        .underrun  (underrun)
    );

endmodule

// File: rtl/lacq_refill_sel_chk.sv
`timescale 1ns/1ps
module lacq_refill_sel_chk #(
    parameter int NQ     = 4,
    parameter int BLEN   = 2,
    parameter int LOOK   = 8,
    parameter int HDEPTH = 10
) (
    input logic                                  clk,
    input logic                                  rst,
    input logic                                  serve_valid,
    input logic                                  underrun,
    input logic                                  refill_valid,
    input logic [lacq_pkg::idx_w(NQ)-1:0]        refill_qid,
    input logic [1:0]                            refill_reason,
    input logic [lacq_pkg::idx_w(HDEPTH+1)-1:0]  occ  [NQ],
    input logic [lacq_pkg::idx_w(LOOK+1)-1:0]    pend [NQ]
);

    logic any_short;

    always_comb begin
        any_short = 1'b0;
        for (int q = 0; q < NQ; q++)
            if (int'(pend[q]) > int'(occ[q])) any_short = 1'b1;
    end

    // R1: lookahead comes out of reset empty
    p_empty_after_reset_r1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!serve_valid && !underrun));

    // R3: grants are spaced by the refill period
    p_refill_spacing_r3: assert property (@(posedge clk) disable iff (rst)
        (refill_valid && BLEN > 1) |=> !refill_valid);

    // R4: a critical grant goes to a queue short of bytes
    p_crit_short_r4: assert property (@(posedge clk) disable iff (rst)
        (refill_valid && refill_reason == 2'd1) |->
            (int'(pend[refill_qid]) > int'(occ[refill_qid])));

    // R5: a deficit grant only when nothing is critical
    p_deficit_calm_r5: assert property (@(posedge clk) disable iff (rst)
        (refill_valid && refill_reason == 2'd2) |-> !any_short);

    // R6: a grant always fits in the head cache
    p_grant_fits_r6: assert property (@(posedge clk) disable iff (rst)
        refill_valid |-> (int'(occ[refill_qid]) + BLEN <= HDEPTH));

    // R7: underrun only on a served slot
    p_underrun_served_r7: assert property (@(posedge clk) disable iff (rst)
        underrun |-> serve_valid);

    // R6: counts stay within the cache depth
    always @(posedge clk) begin
        if (!rst) begin
            for (int q = 0; q < NQ; q++)
                p_no_overflow_r6: assert (int'(occ[q]) <= HDEPTH);
        end
    end

endmodule

bind lacq_refill_sel lacq_refill_sel_chk #(
    .NQ(NQ), .BLEN(BLEN), .LOOK(LOOK), .HDEPTH(HDEPTH)
) u_chk (
    .clk           (clk),
    .rst           (rst),
    .serve_valid   (serve_valid),
    .underrun      (underrun),
    .refill_valid  (refill_valid),
    .refill_qid    (refill_qid),
    .refill_reason (refill_reason),
    .occ           (occ),
    .pend          (pend)
);

// File: tb/lacq_refill_sel_tb.sv
`timescale 1ns/1ps
module lacq_refill_sel_tb;

    localparam int NQ   = 4;
    localparam int BLEN = 2;
    localparam int LK0  = NQ * BLEN;
    localparam int HD0  = LK0 + BLEN;
    localparam int LK1  = 2;
    localparam int HD1  = 4;
    localparam int QW   = 2;

    typedef struct {
        bit sv; int sq; bit ur; bit tick; bit rv; int rq; int rr;
    } exp_t;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          req_valid = 1'b0;
    logic [QW-1:0] req_qid = '0;

    logic          sv [2];
    logic [QW-1:0] sq [2];
    logic          ur [2];
    logic          rv [2];
    logic [QW-1:0] rq [2];
    logic [1:0]    rr [2];

    always #2.5 clk = ~clk;

    lacq_refill_sel #(.NQ(NQ), .BLEN(BLEN)) u_dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_qid(req_qid),
        .serve_valid(sv[0]), .serve_qid(sq[0]), .underrun(ur[0]),
        .refill_valid(rv[0]), .refill_qid(rq[0]), .refill_reason(rr[0])
    );

    // Lookahead deliberately shorter than the no-underrun bound.
    lacq_refill_sel #(.NQ(NQ), .BLEN(BLEN), .LOOK(LK1), .HDEPTH(HD1)) u_dut_short (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_qid(req_qid),
        .serve_valid(sv[1]), .serve_qid(sq[1]), .underrun(ur[1]),
        .refill_valid(rv[1]), .refill_qid(rq[1]), .refill_reason(rr[1])
    );

    int   lk [2] = '{LK0, LK1};
    int   hd [2] = '{HD0, HD1};
    int   la_m  [2][LK0];
    int   occ_m [2][NQ];
    int   ph_m  [2];
    exp_t sb0 [$];
    exp_t sb1 [$];
    int   checks = 0;
    int   errors = 0;
    int   ur_dut [2] = '{0, 0};
    int   ur_exp [2] = '{0, 0};
    bit   done = 1'b0;

    task automatic model_reset();
        for (int m = 0; m < 2; m++) begin
            for (int i = 0; i < LK0; i++) la_m[m][i] = -1;
            for (int q = 0; q < NQ; q++) occ_m[m][q] = 0;
            ph_m[m] = 0;
        end
    endtask

    // Expected outputs for the current model state (R2..R7).
    function automatic exp_t predict(int m);
        exp_t e;
        int   run [NQ];
        bit   found;
        int   cq, bq, bd, d, av, qq;
        found = 0; cq = 0; bq = -1; bd = 0;
        for (int q = 0; q < NQ; q++) run[q] = 0;
        for (int i = 0; i < lk[m]; i++) begin
            qq = la_m[m][i];
            if (qq >= 0) begin
                run[qq]++;
                if (!found && run[qq] > occ_m[m][qq]) begin found = 1; cq = qq; end
            end
        end
        e.tick = (ph_m[m] == BLEN - 1);
        e.rv = 0; e.rq = 0; e.rr = 0;
        if (found) begin
            if (occ_m[m][cq] + BLEN <= hd[m]) begin e.rv = e.tick; e.rq = cq; e.rr = 1; end
        end else begin
            for (int q = 0; q < NQ; q++) begin
                if (occ_m[m][q] + BLEN <= hd[m]) begin
                    d = run[q] - occ_m[m][q];
                    if (bq < 0 || d > bd) begin bq = q; bd = d; end
                end
            end
            if (bq >= 0) begin e.rv = e.tick; e.rq = bq; e.rr = 2; end
        end
        if (!e.rv) e.rr = 0;
        e.sv = (la_m[m][0] >= 0);
        e.sq = e.sv ? la_m[m][0] : 0;
        av = e.sv ? occ_m[m][e.sq] + ((e.rv && e.rq == e.sq) ? BLEN : 0) : 1;
        e.ur = e.sv && (av == 0);
        return e;
    endfunction

    task automatic advance(int m, exp_t e, bit v, int q);
        int av;
        for (int k = 0; k < NQ; k++) begin
            av = occ_m[m][k] + ((e.rv && e.rq == k) ? BLEN : 0);
            if (e.sv && e.sq == k && av > 0) av--;
            occ_m[m][k] = av;
        end
        for (int i = 0; i < lk[m] - 1; i++) la_m[m][i] = la_m[m][i+1];
        la_m[m][lk[m]-1] = v ? q : -1;
        ph_m[m] = e.tick ? 0 : ph_m[m] + 1;
    endtask

    // Driver: push the expectation for this cycle, then apply the input.
    task automatic step(bit v, int q);
        exp_t e;
        for (int m = 0; m < 2; m++) begin
            e = predict(m);
            if (e.ur) ur_exp[m]++;
            if (m == 0) sb0.push_back(e); else sb1.push_back(e);
            advance(m, e, v, q);
        end
        req_valid = v;
        req_qid   = QW'(q);
        @(negedge clk);
    endtask

    task automatic compare(int m, exp_t e);
        bit    bad;
        string tag;
        bad = 0; tag = "";
        checks++;
        if (ur[m] === 1'b1) ur_dut[m]++;
        if (ur[m] !== e.ur) begin bad = 1; tag = "R7"; end
        if (rv[m] !== e.rv || (e.rv && (int'(rq[m]) != e.rq || int'(rr[m]) != e.rr))) begin
            bad = 1;
            tag = !e.tick ? "R3" : (e.rr == 1) ? "R4" : (e.rr == 2) ? "R5" : "R6";
        end
        if (sv[m] !== e.sv || (e.sv && int'(sq[m]) != e.sq)) begin bad = 1; tag = "R2"; end
        if (bad) begin
            errors++;
            $display("FAIL %s dut%0d t=%0t actual sv=%0d sq=%0d ur=%0d rv=%0d rq=%0d rr=%0d expected sv=%0d sq=%0d ur=%0d rv=%0d rq=%0d rr=%0d",
                     tag, m, $time, sv[m], sq[m], ur[m], rv[m], rq[m], rr[m],
                     e.sv, e.sq, e.ur, e.rv, e.rq, e.rr);
        end
    endtask

    // Monitor: sample away from the rising edge and pop the scoreboard.
    initial begin
        forever begin
            @(negedge clk);
            #1;
            if (sb0.size() > 0) compare(0, sb0.pop_front());
            if (sb1.size() > 0) compare(1, sb1.pop_front());
        end
    end

    task automatic do_reset();
        rst = 1'b1;
        req_valid = 1'b0;
        repeat (2) @(negedge clk);
        #1;
        for (int m = 0; m < 2; m++) begin
            checks++;
            if (sv[m] !== 1'b0 || ur[m] !== 1'b0 || rv[m] !== 1'b0) begin
                errors++;
                $display("FAIL R1 dut%0d reset state actual sv=%0d ur=%0d rv=%0d expected 0 0 0",
                         m, sv[m], ur[m], rv[m]);
            end
        end
        @(negedge clk);
        rst = 1'b0;
        model_reset();
    endtask

    initial begin
        model_reset();
        do_reset();
        // Idle: fallback ties go to the lowest index, caches fill, then R6 suppression.
        repeat (30) step(1'b0, 0);
        // Single-queue burst: critical selection (R4).
        repeat (20) step(1'b1, 2);
        // Round robin over all queues.
        for (int i = 0; i < 40; i++) step(1'b1, i % NQ);
        // Random, about three requests in four slots.
        for (int i = 0; i < 400; i++)
            step($urandom_range(3) != 0, int'($urandom_range(NQ - 1)));
        // Round robin starting from empty caches.
        do_reset();
        for (int i = 0; i < 60; i++) step(1'b1, i % NQ);
        // Skewed toward the highest queue, full load.
        for (int i = 0; i < 300; i++)
            step(1'b1, ($urandom_range(3) == 0) ? int'($urandom_range(NQ - 1)) : NQ - 1);
        repeat (12) step(1'b0, 0);

        // R8: the default instance never runs dry.
        checks++;
        if (ur_dut[0] != 0) begin
            errors++;
            $display("FAIL R8 underrun count actual %0d expected 0", ur_dut[0]);
        end
        // R7: the short-lookahead instance does run dry, exactly as modelled.
        checks++;
        if (ur_exp[1] == 0 || ur_dut[1] != ur_exp[1]) begin
            errors++;
            $display("FAIL R7 short-lookahead underrun count actual %0d expected %0d (nonzero)",
                     ur_dut[1], ur_exp[1]);
        end
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired actual running expected finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule